// File: doc/BRIEF.md
# Pause Frame Request Generator

This block turns a two-bit flow-control request from a client into MAC control pause frames on a 32-bit transmit stream. The stream has start, end, valid, ready and byte-empty signals. Code 2 asks the link partner to stop sending, and the block sends an XOFF frame that carries the quanta value from a register. Code 1 asks the partner to resume, and the block sends an XON frame whose quanta field is zero. Code 0 stops generation. Code 3 is reserved and is ignored.

The block keeps the last accepted request. It emits exactly one frame each time the request changes to a sending code. The request only takes effect while both bits of a two-bit mode field are zero. Each frame is a complete minimum-size frame:
- the reserved multicast destination,
- the station source address,
- the control type and the pause opcode,
- the quanta,
- zero padding up to 60 bytes,
- four zero bytes that hold the place of the check sequence, which is filled in further down the transmit path.

Arbitration against client data frames happens outside this block.

Top module: `pause_frame_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tx_valid` is low. The value of `tx_ready` during reset has no effect.
- R2: A request of code 2 produces a frame whose quanta bytes equal `quanta_reg`, sampled when the frame starts. A request of code 1 produces a frame whose quanta bytes are 0x0000.
- R3: A frame is 16 beats. Byte 0 of the frame is carried on `tx_data[31:24]` of the first beat, and later bytes follow most-significant lane first. The byte sequence is:
  - 01 80 C2 00 00 01;
  - `src_mac[47:40]` down to `src_mac[7:0]`;
  - 88 08;
  - 00 01;
  - the quanta, high byte first;
  - zero bytes up to byte 63.
- R4: `tx_sop` is high on the first beat only and `tx_eop` on the sixteenth beat only. `tx_empty` is 0 on the end beat, because all four bytes are valid.
- R5: A beat is consumed only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid`, `tx_data`, `tx_sop` and `tx_eop` hold their values.
- R6: Exactly one frame is sent per change of the accepted request. Repeating the current code sends nothing. Code 3 is ignored and is not recorded as the current code.
- R7: Code 0 sends no frame. If it arrives before a pending frame has started, the pending frame is cancelled.
- R8: A request is accepted only while `ctl_mode` is 2'b00. While `ctl_mode` is nonzero, request changes are not recorded. Once `ctl_mode` returns to zero, the request is compared against the last code that was accepted.
- R9: A request change that arrives while a frame is being sent does not alter that frame. The change is held and sent after the frame ends. If several changes arrive during one frame, only the latest is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_code | input | 2 | Client request: 0 stop, 1 XON, 2 XOFF, 3 reserved |
| ctl_mode | input | 2 | Mode bits; the client request is honoured only when both are zero |
| quanta_reg | input | 16 | Pause quanta placed in XOFF frames |
| src_mac | input | 48 | Station source address |
| tx_ready | input | 1 | Downstream can take a beat |
| tx_valid | output | 1 | Beat on the stream is valid |
| tx_sop | output | 1 | First beat of a frame |
| tx_eop | output | 1 | Last beat of a frame |
| tx_data | output | 32 | Frame bytes, first byte in bits 31:24 |
| tx_empty | output | 2 | Count of unused bytes on the end beat |

## Verification
A new request can arrive in the same cycle that the last beat of the current frame is accepted. In that cycle the frame must close and the new request must be latched, with nothing lost and nothing repeated. The bench provokes this by changing `req_code` just before the clock edge that accepts the end beat. It then checks that exactly one further frame of the new kind follows, with a correct header. The same collision is also provoked while `tx_ready` is pseudo-randomly deasserted.

// File: rtl/pause_frame_gen.sv
module pause_frame_gen #(
  parameter int MIN_BYTES = 60,
  parameter int FCS_BYTES = 4,
  parameter int QW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    req_code,
  input  logic [1:0]    ctl_mode,
  input  logic [QW-1:0] quanta_reg,
  input  logic [47:0]   src_mac,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic          tx_sop,
  output logic          tx_eop,
  output logic [31:0]   tx_data,
  output logic [1:0]    tx_empty
);
  localparam int TOTAL = MIN_BYTES + FCS_BYTES;
  localparam int BEATS = (TOTAL + 3) / 4;
  localparam int CW    = $clog2(BEATS);
  localparam logic [1:0]    LAST_EMPTY = 2'(BEATS * 4 - TOTAL);
  localparam logic [CW-1:0] LAST_BEAT  = CW'(BEATS - 1);

  logic [1:0]    last_q;
  logic          pend_q, pend_xoff_q, busy_q;
  logic [QW-1:0] q_q;
  logic [CW-1:0] beat_q;

  wire gate_open = (ctl_mode == 2'b00);
  wire chg       = gate_open && (req_code != 2'b11) && (req_code != last_q);
  wire fire      = busy_q && tx_ready;
  wire at_last   = (beat_q == LAST_BEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q      <= 2'b00;
      pend_q      <= 1'b0;
      pend_xoff_q <= 1'b0;
      busy_q      <= 1'b0;
      q_q         <= '0;
      beat_q      <= '0;
    end else begin
      if (!busy_q && pend_q) begin
        busy_q <= 1'b1;
        beat_q <= '0;
        q_q    <= pend_xoff_q ? quanta_reg : '0;
        pend_q <= 1'b0;
      end
      if (fire) begin
        beat_q <= beat_q + 1'b1;
        if (at_last) busy_q <= 1'b0;
      end
      if (chg) begin
        last_q      <= req_code;
        pend_q      <= (req_code != 2'b00);
        pend_xoff_q <= (req_code == 2'b10);
      end
    end
  end

  function automatic logic [7:0] byte_at(int idx, logic [QW-1:0] q, logic [47:0] sa);
    logic [7:0] b;
    case (idx)
      0:  b = 8'h01;
      1:  b = 8'h80;
      2:  b = 8'hC2;
      3:  b = 8'h00;
      4:  b = 8'h00;
      5:  b = 8'h01;
      6:  b = sa[47:40];
      7:  b = sa[39:32];
      8:  b = sa[31:24];
      9:  b = sa[23:16];
      10: b = sa[15:8];
      11: b = sa[7:0];
      12: b = 8'h88;
      13: b = 8'h08;
      14: b = 8'h00;
      15: b = 8'h01;
      16: b = q[QW-1 -: 8];
      17: b = q[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  always_comb begin
    tx_data = '0;
    for (int k = 0; k < 4; k++)
      tx_data[31-8*k -: 8] = byte_at(int'(beat_q) * 4 + k, q_q, src_mac);
  end

  assign tx_valid = busy_q;
  assign tx_sop   = busy_q && (beat_q == '0);
  assign tx_eop   = busy_q && at_last;
  assign tx_empty = tx_eop ? LAST_EMPTY : 2'b00;
endmodule

// File: rtl/pause_frame_gen_chk.sv
module pause_frame_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_ready,
  input logic        tx_valid,
  input logic        tx_sop,
  input logic        tx_eop,
  input logic [31:0] tx_data,
  input logic [1:0]  tx_empty
);
  a_r1_idle_in_reset: assert property (@(posedge clk) !rst_n |=> !tx_valid);

  a_r5_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop));

  a_r4_empty_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_eop |-> tx_empty == 2'b00);

  a_r4_sop_not_eop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(tx_sop && tx_eop));

  a_r3_dest_first: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_sop |-> tx_data == 32'h0180C200);

  a_r9_gap_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_eop |=> !tx_valid);
endmodule

bind pause_frame_gen pause_frame_gen_chk u_chk (.*);

// File: tb/test_pause_frame_gen.sv
module test_pause_frame_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req_code = 2'b00;
  logic [1:0]  ctl_mode = 2'b00;
  logic [15:0] quanta_reg = 16'h1234;
  logic [47:0] src_mac = 48'hA1B2C3D4E5F6;
  logic        tx_ready = 1'b1;
  logic        tx_valid, tx_sop, tx_eop;
  logic [31:0] tx_data;
  logic [1:0]  tx_empty;

  always #5 clk = ~clk;

  pause_frame_gen i_pause_frame_gen (.*);

  int checks = 0, fails = 0, launches = 0, frames = 0;
  bit rdy_rand = 0;
  logic [7:0] lfsr = 8'h5A;
  logic [1:0] mlast = 2'b00;
  bit mpend = 0, mpend_xoff = 0, launched = 0, done = 0;
  logic [16:0] expq[$];
  logic [31:0] cap[16];
  int idx = 0;
  bit inframe = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] eb(int i, logic [15:0] q);
    logic [7:0] hdr[18];
    hdr = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01,
            src_mac[47:40], src_mac[39:32], src_mac[31:24],
            src_mac[23:16], src_mac[15:8], src_mac[7:0],
            8'h88, 8'h08, 8'h00, 8'h01, q[15:8], q[7:0]};
    return (i < 18) ? hdr[i] : 8'h00;
  endfunction

  always @(posedge clk) begin
    #2;
    if (rdy_rand) begin
      lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready <= lfsr[0] | lfsr[3];
    end else tx_ready <= 1'b1;
  end

  // launch detection: pending model item becomes an expected frame
  always @(posedge clk) begin
    #1;
    if (rst_n && tx_valid && tx_sop && !launched) begin
      launched = 1;
      launches++;
      if (mpend) begin
        expq.push_back({mpend_xoff, mpend_xoff ? quanta_reg : 16'h0000});
        mpend = 0;
      end else begin
        expq.push_back(17'h1FFFF);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (tx_sop) begin
        if (inframe) chk(0, "R4", "sop inside frame", idx, 0);
        inframe = 1;
        idx = 0;
      end
      if (inframe) begin
        if (idx < 16) cap[idx] = tx_data;
        if (tx_eop) begin
          logic [16:0] e;
          bit ok;
          int bad;
          chk(idx == 15 && tx_empty == 2'b00, "R4", "end beat index/empty", {idx, tx_empty}, {15, 2'b00});
          ok = 1; bad = 0;
          if (expq.size() == 0) begin
            chk(0, "R6", "unexpected frame", 1, 0);
          end else begin
            e = expq.pop_front();
            for (int b = 0; b < 16; b++) begin
              logic [31:0] w;
              w = {eb(4*b, e[15:0]), eb(4*b+1, e[15:0]), eb(4*b+2, e[15:0]), eb(4*b+3, e[15:0])};
              if (ok && cap[b] !== w) begin ok = 0; bad = b; end
            end
            chk(ok && e != 17'h1FFFF, "R2/R3", $sformatf("frame content beat %0d", bad),
                cap[bad], {eb(4*bad, e[15:0]), eb(4*bad+1, e[15:0]), eb(4*bad+2, e[15:0]), eb(4*bad+3, e[15:0])});
          end
          frames++;
          inframe = 0;
          launched = 0;
        end else idx++;
      end
    end
  end

  task automatic apply(logic [1:0] c);
    req_code = c;
    if (ctl_mode == 2'b00 && c != 2'b11 && c != mlast) begin
      mlast = c;
      mpend = (c != 2'b00);
      mpend_xoff = (c == 2'b10);
    end
  endtask

  task automatic set_req(logic [1:0] c);
    @(posedge clk); #3;
    apply(c);
  endtask

  task automatic drain(string req);
    int n = 0;
    while ((mpend || expq.size() != 0 || tx_valid || launched) && n < 2000) begin
      @(posedge clk); n++;
    end
    repeat (4) @(posedge clk);
    chk(!mpend && expq.size() == 0, req, "all expected frames seen", expq.size(), 0);
  endtask

  task automatic expect_quiet(string req, int l0);
    repeat (60) @(posedge clk);
    chk(launches == l0, req, "no frame started", launches, l0);
  endtask

  task automatic wait_sop;
    while (!(tx_valid && tx_sop)) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic wait_end_accept;
    forever begin
      @(posedge clk); #3;
      if (tx_valid && tx_ready && tx_eop) break;
    end
  endtask

  initial begin
    int l0;
    repeat (3) @(posedge clk);
    #3;
    chk(tx_valid == 1'b0, "R1", "valid in reset", tx_valid, 0);
    rst_n = 1'b1;
    @(posedge clk); #3;
    chk(tx_valid == 1'b0, "R1", "valid after reset", tx_valid, 0);

    // R2: XOFF then XON
    set_req(2'b10); drain("R2");
    set_req(2'b01); drain("R2");

    // R6: repeat of current code, reserved code
    l0 = launches; set_req(2'b01); expect_quiet("R6", l0);
    set_req(2'b11); expect_quiet("R6", l0);
    set_req(2'b01); expect_quiet("R6", l0);
    quanta_reg = 16'h00FF;
    set_req(2'b10); drain("R6");
    chk(frames == 3, "R6", "frame count", frames, 3);

    // R8: gate closed, then reopen with a differing code
    @(posedge clk); #3; ctl_mode = 2'b10;
    l0 = launches; set_req(2'b01); expect_quiet("R8", l0);
    @(posedge clk); #3; ctl_mode = 2'b01; set_req(2'b00); expect_quiet("R8", l0);
    set_req(2'b01);
    @(posedge clk); #3; ctl_mode = 2'b00;
    if (2'b01 != mlast) begin mlast = 2'b01; mpend = 1; mpend_xoff = 0; end
    drain("R8");

    // R7: stop sends nothing
    l0 = launches; set_req(2'b00); expect_quiet("R7", l0);

    // R5: back-pressure
    quanta_reg = 16'hBEEF; rdy_rand = 1;
    set_req(2'b10); drain("R5");
    rdy_rand = 0;

    // R9: mid-frame change held, latest wins
    set_req(2'b01); wait_sop;
    set_req(2'b10); set_req(2'b01);
    drain("R9");
    // R7: cancel of a held request during a frame
    set_req(2'b10); wait_sop;
    set_req(2'b01); set_req(2'b00);
    drain("R7");
    l0 = launches; expect_quiet("R7", l0);

    // same-cycle: change lands on end-beat acceptance
    set_req(2'b01); wait_end_accept; apply(2'b10); drain("R9");
    rdy_rand = 1;
    quanta_reg = 16'h0A0B;
    set_req(2'b01); wait_end_accept; apply(2'b10); drain("R9");
    rdy_rand = 0;
    chk(frames == launches, "R4", "frames closed", frames, launches);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule